// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit holds the status byte of a serial non-volatile memory and decides whether each write request from the protocol engine may go ahead. Three of its bits are persistent: a lock-enable flag and a two-bit range code. The remaining bits are a write-enable latch and a busy flag. The persistent bits survive a soft reset and are cleared only by the power-on reset. Both the status byte and the range code are checked against the level of an active-low write-protect pin, the state of the write-enable latch and the busy indication from the program sequencer.

Each command arrives as a single-cycle pulse at the point where the protocol engine completes it. The grant and deny outputs are combinational in that same cycle, so the engine can start or drop a program cycle without waiting. While a program cycle runs, the readable persistent bits keep their values from before the cycle. The latch and busy bits are shown live. Serial shifting is handled elsewhere.

Top module: `sr_protect_unit`

## Requirements
- R1: `status_o` layout: bit 7 = lock-enable, bits 6..4 = 0, bit 3 = range code high bit, bit 2 = range code low bit, bit 1 = write-enable latch, bit 0 = busy flag.
- R2: A low `rst_ni` clears the whole status byte to 0x00. `soft_rst_i` clears only the write-enable latch and leaves bits 7, 3 and 2 unchanged.
- R3: `set_wel_i` sets the latch. `clr_wel_i`, `wr_status_i` and `wr_array_i` clear it from the next cycle, whether or not the write was granted.
- R4: A status write is granted only when the latch is set, `busy_i` is low and the hardware lock is inactive. A granted write stores `status_din_i` bits 7, 3 and 2. Its other bits have no effect on the latch or on the busy flag.
- R5: The hardware lock is active when the stored lock-enable bit is 1 and `wp_pin_i` is low, whichever of the two happened last. It is released only by `wp_pin_i` going high, and the range code is kept.
- R6: `addr_protected_o` depends on the range code and the top two bits of `array_addr_i`. Code 00 protects nothing. Code 01 protects addresses whose top bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address.
- R7: An array write is granted only when the latch is set, `busy_i` is low and the address is not protected. Otherwise `array_deny_o` is asserted.
- R8: Bit 0 of `status_o` follows `busy_i` in the same cycle.
- R9: While `busy_i` is high, bits 7, 3 and 2 of `status_o` show the values held in the last cycle before busy rose. In the first cycle with `busy_i` low again, they show the stored values.
- R10: Any status or array write requested while `busy_i` is high is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async power-on reset |
| soft_rst_i | input | 1 | Synchronous soft reset, clears the latch only |
| wp_pin_i | input | 1 | Write-protect pin level, low = protect |
| busy_i | input | 1 | Program cycle active, from sequencer |
| set_wel_i | input | 1 | Set-enable command pulse |
| clr_wel_i | input | 1 | Clear-enable command pulse |
| wr_status_i | input | 1 | Status write command pulse |
| status_din_i | input | 8 | Status write data |
| wr_array_i | input | 1 | Array write command pulse |
| array_addr_i | input | ADDR_W | Array write start address |
| status_o | output | 8 | Readable status byte |
| status_grant_o | output | 1 | Status write accepted |
| status_deny_o | output | 1 | Status write refused |
| array_grant_o | output | 1 | Array write accepted |
| array_deny_o | output | 1 | Array write refused |
| addr_protected_o | output | 1 | `array_addr_i` lies in the protected range |

## Verification
The assertions assume that at most one command pulse is high in any cycle. They also assume that the sequencer raises `busy_i` no earlier than the cycle after a grant and keeps it stable across a cycle, so that a freeze window is well defined. The bench drives every command alone for one cycle, on the falling edge. It raises busy only after the cycle of a granted write and clears it before issuing further commands, except in the scenario that deliberately probes requests made during busy.

// File: rtl/sr_prot_pkg.sv
package sr_prot_pkg;
  localparam int unsigned SR_W     = 8;
  localparam int unsigned B_LOCK   = 7;
  localparam int unsigned B_RNG_HI = 3;
  localparam int unsigned B_RNG_LO = 2;
  localparam int unsigned B_WEL    = 1;
  localparam int unsigned B_BUSY   = 0;

  typedef enum logic [1:0] {
    RNG_NONE    = 2'b00,
    RNG_QUARTER = 2'b01,
    RNG_HALF    = 2'b10,
    RNG_ALL     = 2'b11
  } rng_code_e;

  typedef struct packed {
    logic      lock;
    rng_code_e rng;
  } nv_bits_t;
endpackage

// File: rtl/sr_range_check.sv
module sr_range_check
  import sr_prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  rng_code_e         rng_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int unsigned TOP_LSB = ADDR_W - 2;

  logic [1:0] top;
  assign top = addr_i[TOP_LSB +: 2];

  always_comb begin
    unique case (rng_i)
      RNG_NONE:    prot_o = 1'b0;
      RNG_QUARTER: prot_o = (top == 2'b11);
      RNG_HALF:    prot_o = top[1];
      default:     prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_write_gate.sv
module sr_write_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_status_i,
  input  logic wr_array_i,
  input  logic wel_i,
  input  logic busy_i,
  input  logic lock_i,
  input  logic wp_pin_i,
  input  logic prot_i,
  output logic status_grant_o,
  output logic status_deny_o,
  output logic array_grant_o,
  output logic array_deny_o
);
  logic hw_lock;
  logic ok_base;

  // lock follows whichever of lock bit / pin low came last: pure level AND
  assign hw_lock        = lock_i & ~wp_pin_i;
  assign ok_base        = wel_i & ~busy_i;
  assign status_grant_o = wr_status_i & ok_base & ~hw_lock;
  assign status_deny_o  = wr_status_i & ~status_grant_o;
  assign array_grant_o  = wr_array_i & ok_base & ~prot_i;
  assign array_deny_o   = wr_array_i & ~array_grant_o;

  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(status_grant_o || array_grant_o));
  assert_one_verdict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_array_i |-> (array_grant_o ^ array_deny_o));
endmodule

// File: rtl/sr_status_store.sv
module sr_status_store
  import sr_prot_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic            busy_i,
  input  logic            set_wel_i,
  input  logic            clr_wel_i,
  input  logic            nv_we_i,
  input  nv_bits_t        nv_din_i,
  output logic            wel_o,
  output nv_bits_t        nv_o,
  output logic [SR_W-1:0] status_o
);
  logic     wel_q;
  nv_bits_t nv_q, frz_q, view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (soft_rst_i || clr_wel_i) begin
      wel_q <= 1'b0;
    end else if (set_wel_i) begin
      wel_q <= 1'b1;
    end
  end

  // persistent bits: power-on reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q <= '{lock: 1'b0, rng: RNG_NONE};
    end else if (nv_we_i) begin
      nv_q <= nv_din_i;
    end
  end

  // snapshot kept while a program cycle runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= '{lock: 1'b0, rng: RNG_NONE};
    end else if (!busy_i) begin
      frz_q <= nv_q;
    end
  end

  assign view  = busy_i ? frz_q : nv_q;
  assign wel_o = wel_q;
  assign nv_o  = nv_q;

  always_comb begin
    status_o           = '0;
    status_o[B_LOCK]   = view.lock;
    status_o[B_RNG_HI] = view.rng[1];
    status_o[B_RNG_LO] = view.rng[0];
    status_o[B_WEL]    = wel_q;
    status_o[B_BUSY]   = busy_i;
  end

  assert_wel_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wel_i |=> !wel_o);
  assert_soft_keeps_nv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !nv_we_i) |=> $stable(nv_o));
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
  import sr_prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wp_pin_i,
  input  logic              busy_i,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              wr_status_i,
  input  logic [SR_W-1:0]   status_din_i,
  input  logic              wr_array_i,
  input  logic [ADDR_W-1:0] array_addr_i,
  output logic [SR_W-1:0]   status_o,
  output logic              status_grant_o,
  output logic              status_deny_o,
  output logic              array_grant_o,
  output logic              array_deny_o,
  output logic              addr_protected_o
);
  logic     wel;
  logic     any_clr;
  nv_bits_t nv, nv_din;

  assign any_clr     = clr_wel_i | wr_status_i | wr_array_i;
  assign nv_din.lock = status_din_i[B_LOCK];
  assign nv_din.rng  = rng_code_e'({status_din_i[B_RNG_HI], status_din_i[B_RNG_LO]});

  sr_range_check #(.ADDR_W(ADDR_W)) u_range (
    .rng_i  (nv.rng),
    .addr_i (array_addr_i),
    .prot_o (addr_protected_o)
  );

  sr_write_gate u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_status_i    (wr_status_i),
    .wr_array_i     (wr_array_i),
    .wel_i          (wel),
    .busy_i         (busy_i),
    .lock_i         (nv.lock),
    .wp_pin_i       (wp_pin_i),
    .prot_i         (addr_protected_o),
    .status_grant_o (status_grant_o),
    .status_deny_o  (status_deny_o),
    .array_grant_o  (array_grant_o),
    .array_deny_o   (array_deny_o)
  );

  sr_status_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .busy_i     (busy_i),
    .set_wel_i  (set_wel_i),
    .clr_wel_i  (any_clr),
    .nv_we_i    (status_grant_o),
    .nv_din_i   (nv_din),
    .wel_o      (wel),
    .nv_o       (nv),
    .status_o   (status_o)
  );

  assert_cmd_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_wel_i, clr_wel_i, wr_status_i, wr_array_i}));
  assert_grant_needs_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_grant_o || array_grant_o) |-> status_o[B_WEL]);
  assert_no_prot_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_grant_o |-> !addr_protected_o);
  assert_nv_only_on_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_grant_o |=> $stable(nv));
  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(status_o[7:2]));
  assert_busy_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> status_o[B_BUSY]);
  assert_unused_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);
endmodule

// File: tb/tb_sr_protect_unit.sv
module tb_sr_protect_unit;
  localparam int unsigned ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              soft_rst = 1'b0, wp_pin = 1'b1, busy = 1'b0;
  logic              set_wel = 1'b0, clr_wel = 1'b0, wr_st = 1'b0, wr_arr = 1'b0;
  logic [7:0]        st_din = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        st;
  logic              st_gnt, st_dny, ar_gnt, ar_dny, prot;
  int                n_run = 0, n_fail = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  sr_protect_unit #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .wp_pin_i(wp_pin),
    .busy_i(busy), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
    .wr_status_i(wr_st), .status_din_i(st_din), .wr_array_i(wr_arr),
    .array_addr_i(addr), .status_o(st), .status_grant_o(st_gnt),
    .status_deny_o(st_dny), .array_grant_o(ar_gnt), .array_deny_o(ar_dny),
    .addr_protected_o(prot)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wel();
    @(negedge clk); set_wel = 1'b1;
    @(negedge clk); set_wel = 1'b0;
  endtask

  // status write; grant checked mid-cycle
  task automatic do_wrsr(input logic [7:0] d, input bit exp_gnt, input string req);
    @(negedge clk); wr_st = 1'b1; st_din = d;
    #1 chk(req, {st_gnt, st_dny}, exp_gnt ? 2'b10 : 2'b01);
    @(negedge clk); wr_st = 1'b0; st_din = '0;
  endtask

  task automatic do_arr(input logic [ADDR_W-1:0] a, input bit exp_prot, input string req);
    do_wel();
    @(negedge clk); wr_arr = 1'b1; addr = a;
    #1 chk({req, " range"}, prot, exp_prot);
    chk({req, " verdict"}, {ar_gnt, ar_dny}, exp_prot ? 2'b01 : 2'b10);
    @(negedge clk); wr_arr = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R2 por", st, 8'h00);
  endtask

  task automatic t_wel();
    do_wel();       chk("R3 set R1 bit1", st, 8'h02);
    @(negedge clk); clr_wel = 1'b1;
    @(negedge clk); clr_wel = 1'b0; chk("R3 clear", st, 8'h00);
  endtask

  task automatic t_wrsr();
    do_wrsr(8'hFF, 1'b0, "R4 no latch");
    chk("R4 unchanged", st, 8'h00);
    do_wel();
    do_wrsr(8'hFF, 1'b1, "R4 grant");
    chk("R4 R1 stored bits only, R3 latch cleared", st, 8'h8C);
  endtask

  task automatic t_freeze();
    do_wel();
    @(negedge clk); wr_st = 1'b1; st_din = 8'h04;
    #1 chk("R4 grant", st_gnt, 1);
    @(negedge clk); wr_st = 1'b0; busy = 1'b1;
    #1 chk("R9 frozen R8 busy", st, 8'h8D);
    // requests during busy
    set_wel = 1'b1;
    @(negedge clk); set_wel = 1'b0;
    chk("R3 latch live during busy", st, 8'h8F);
    wr_st = 1'b1; st_din = 8'h00;
    #1 chk("R10 status denied", {st_gnt, st_dny}, 2'b01);
    @(negedge clk); wr_st = 1'b0;
    do_wel();
    @(negedge clk); wr_arr = 1'b1; addr = '0;
    #1 chk("R10 array denied", {ar_gnt, ar_dny}, 2'b01);
    @(negedge clk); wr_arr = 1'b0;
    chk("R9 still frozen", st, 8'h8D);
    busy = 1'b0;
    #1 chk("R9 R8 new value visible", st, 8'h04);
  endtask

  task automatic t_ranges();
    // code 01 now stored
    do_arr(13'h1800, 1'b1, "R6 R7 quarter in");
    do_arr(13'h17FF, 1'b0, "R6 R7 quarter out");
    do_wel(); do_wrsr(8'h08, 1'b1, "R4 set half");
    do_arr(13'h1000, 1'b1, "R6 half in");
    do_arr(13'h0FFF, 1'b0, "R6 half out");
    do_wel(); do_wrsr(8'h0C, 1'b1, "R4 set all");
    do_arr(13'h0000, 1'b1, "R6 all low");
    do_wel(); do_wrsr(8'h00, 1'b1, "R4 set none");
    do_arr(13'h1FFF, 1'b0, "R6 none top");
  endtask

  task automatic t_hwlock();
    do_wel(); do_wrsr(8'h88, 1'b1, "R5 lock set pin high");
    @(negedge clk); wp_pin = 1'b0;
    do_wel(); do_wrsr(8'h00, 1'b0, "R5 locked pin-after");
    chk("R5 held", st, 8'h88);
    @(negedge clk); wp_pin = 1'b1;
    #1 chk("R5 range kept on release", st, 8'h88);
    do_wel(); do_wrsr(8'h00, 1'b1, "R5 released");
    // pin low first, then lock bit set
    @(negedge clk); wp_pin = 1'b0;
    do_wel(); do_wrsr(8'h84, 1'b1, "R5 lock-after allowed");
    do_wel(); do_wrsr(8'h00, 1'b0, "R5 locked lock-after");
    chk("R5 held 2", st, 8'h84);
    @(negedge clk); wp_pin = 1'b1;
  endtask

  task automatic t_soft();
    do_wel();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R2 soft keeps nv", st, 8'h84);
  endtask

  initial begin
    #1 t_reset();
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wel();
    t_wrsr();
    t_freeze();
    t_ranges();
    t_hwlock();
    t_soft();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule